// File: doc/BRIEF.md
# Software Doorbell Interrupt Unit

This unit turns software writes into interrupts. A single trigger word names a doorbell and either a set of CPU targets or, when a redirect flag is set, a bank of message-signalled doorbells. Each ring sets one bit in a 32-bit cause register. That is either the inbound cause register of every targeted CPU or the shared message-signalled cause register.

Every cause register has a mask beside it. Each CPU gets one summary interrupt line, and the message bank gets its own summary line. These lines are meant to feed the lowest-numbered input of a larger interrupt controller and its message input. Software acknowledges a doorbell by writing zero to its cause bit. Bits written as one stay as they are. A ring arriving in the same cycle as a clear always survives.

The trigger port and the register write port are independent, so a ring and a clear can land on the same edge. A combinational read port returns any cause or mask register.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset, every CPU cause register reads 0, every CPU mask reads 0, the message cause reads 0, the message mask reads 0xFFFFFFFF, and all summary lines are low.
- R2: A trigger write with bit 5 clear sets cause bit `data[4:0]` in each CPU i (i < NCPU) whose target bit `data[8+i]` is 1. The cause of every other CPU is left unchanged.
- R3: A trigger write with bit 5 set sets bit `data[4:0]` of the message cause register. No CPU cause register changes, whatever the target bits hold.
- R4: A register write to a cause register (wr_sel 0 for a CPU cause selected by wr_cpu, wr_sel 2 for the message cause) clears each bit written as 0 and keeps each bit written as 1.
- R5: When a ring and a clear reach the same cause bit in the same cycle, the bit ends up set.
- R6: `cpu_irq[i]` is high exactly when CPU i's cause AND its mask (wr_sel 1) is non-zero. `msi_irq` is high exactly when the message cause AND the message mask (wr_sel 3) is non-zero. Both are visible in the cycle after the write edge.
- R7: Writing a mask changes no cause bit. Masking a pending doorbell lowers the summary line, and unmasking it raises the line again.
- R8: Trigger bits 7:6 do not alter the doorbell number, and target bits for CPUs at or above NCPU have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_we | input | 1 | Trigger word write strobe |
| ring_data | input | 32 | Trigger word: [4:0] doorbell, [5] message redirect, [8+i] CPU i target |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 CPU cause, 1 CPU mask, 2 message cause, 3 message mask |
| wr_cpu | input | CIDX_W | CPU index for selects 0 and 1 |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_cpu | input | CIDX_W | CPU index for reads |
| rd_data | output | 32 | Selected register value |
| cpu_irq | output | NCPU | Per-CPU doorbell summary |
| msi_irq | output | 1 | Message doorbell summary |

## Verification
A ring and an acknowledge write can fall in the same cycle, because they arrive on separate ports. The bench provokes this two ways. First, it rings CPU 0's doorbell 9 while writing all zeros to CPU 0's cause. Second, it rings message doorbell 1 while clearing message bit 7. Reading back afterwards must show the rung bit set and the other bit cleared.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;
    localparam int DB_W        = 32;
    localparam int DB_IDX_W    = $clog2(DB_W);
    localparam int REDIRECT_B  = 5;
    localparam int TGT_BASE    = 8;
    localparam int MAX_CPU     = 4;

    typedef enum logic [1:0] {
        SEL_CAUSE     = 2'd0,
        SEL_MASK      = 2'd1,
        SEL_MSI_CAUSE = 2'd2,
        SEL_MSI_MASK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DB_W-1:0] cause;
        logic [DB_W-1:0] mask;
    } bank_t;
endpackage

// File: rtl/ipi_ring_decode.sv
module ipi_ring_decode
    import ipi_doorbell_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                      ring_we,
    input  logic [DB_W-1:0]           ring_data,
    output logic [NCPU-1:0][DB_W-1:0] cpu_ring,
    output logic [DB_W-1:0]           msi_ring
);
    logic [DB_W-1:0] onehot;
    logic            unused_bits;

    assign unused_bits = ^{ring_data[DB_W-1:TGT_BASE+NCPU], ring_data[TGT_BASE-1:REDIRECT_B+1]};

    always_comb begin
        onehot   = DB_W'(1) << ring_data[DB_IDX_W-1:0];
        msi_ring = (ring_we && ring_data[REDIRECT_B]) ? onehot : '0;
        for (int i = 0; i < NCPU; i++) begin
            cpu_ring[i] = (ring_we && !ring_data[REDIRECT_B] && ring_data[TGT_BASE+i])
                          ? onehot : '0;
        end
    end
endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank
    import ipi_doorbell_pkg::*;
#(
    parameter logic [DB_W-1:0] MASK_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] ring,
    input  logic            clr_we,
    input  logic [DB_W-1:0] clr_data,
    input  logic            mask_we,
    input  logic [DB_W-1:0] mask_data,
    output logic [DB_W-1:0] cause,
    output logic [DB_W-1:0] mask,
    output logic            irq
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (mask_we) begin
            bank_d.mask = mask_data;
        end
        // a ring is ORed in after the clear, so it wins on a collision
        bank_d.cause = (clr_we ? (bank_q.cause & clr_data) : bank_q.cause) | ring;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '{cause: '0, mask: MASK_RST};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cause = bank_q.cause;
    assign mask  = bank_q.mask;
    assign irq   = |(bank_q.cause & bank_q.mask);
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_doorbell_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int CIDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_we,
    input  logic [31:0]       ring_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CIDX_W-1:0] wr_cpu,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_sel,
    input  logic [CIDX_W-1:0] rd_cpu,
    output logic [31:0]       rd_data,
    output logic [NCPU-1:0]   cpu_irq,
    output logic              msi_irq
);
    localparam int CSLOTS = 1 << CIDX_W;

    logic [NCPU-1:0][DB_W-1:0]   cpu_ring;
    logic [DB_W-1:0]             msi_ring;
    logic [NCPU-1:0][DB_W-1:0]   cpu_cause;
    logic [NCPU-1:0][DB_W-1:0]   cpu_mask;
    logic [CSLOTS-1:0][DB_W-1:0] cause_pad;
    logic [CSLOTS-1:0][DB_W-1:0] mask_pad;
    logic [DB_W-1:0]             msi_cause;
    logic [DB_W-1:0]             msi_mask;
    reg_sel_e                    wsel;
    reg_sel_e                    rsel;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    ipi_ring_decode #(.NCPU(NCPU)) u_decode (
        .ring_we  (ring_we),
        .ring_data(ring_data),
        .cpu_ring (cpu_ring),
        .msi_ring (msi_ring)
    );

    for (genvar i = 0; i < CSLOTS; i++) begin : g_cpu
        if (i < NCPU) begin : g_live
            ipi_cause_bank #(.MASK_RST('0)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .ring     (cpu_ring[i]),
                .clr_we   (wr_en && wsel == SEL_CAUSE && wr_cpu == CIDX_W'(i)),
                .clr_data (wr_data),
                .mask_we  (wr_en && wsel == SEL_MASK && wr_cpu == CIDX_W'(i)),
                .mask_data(wr_data),
                .cause    (cpu_cause[i]),
                .mask     (cpu_mask[i]),
                .irq      (cpu_irq[i])
            );
            assign cause_pad[i] = cpu_cause[i];
            assign mask_pad[i]  = cpu_mask[i];
        end else begin : g_empty
            assign cause_pad[i] = '0;
            assign mask_pad[i]  = '0;
        end
    end

    ipi_cause_bank #(.MASK_RST('1)) u_msi (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring     (msi_ring),
        .clr_we   (wr_en && wsel == SEL_MSI_CAUSE),
        .clr_data (wr_data),
        .mask_we  (wr_en && wsel == SEL_MSI_MASK),
        .mask_data(wr_data),
        .cause    (msi_cause),
        .mask     (msi_mask),
        .irq      (msi_irq)
    );

    always_comb begin
        unique case (rsel)
            SEL_CAUSE:     rd_data = cause_pad[rd_cpu];
            SEL_MASK:      rd_data = mask_pad[rd_cpu];
            SEL_MSI_CAUSE: rd_data = msi_cause;
            default:       rd_data = msi_mask;
        endcase
    end
endmodule

// File: rtl/ipi_doorbell_chk.sv
module ipi_doorbell_chk #(
    parameter int NCPU = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ring_we,
    input logic [31:0]           ring_data,
    input logic                  wr_en,
    input logic [1:0]            wr_sel,
    input logic [31:0]           wr_data,
    input logic [NCPU-1:0][31:0] cpu_cause,
    input logic [31:0]           msi_cause,
    input logic [NCPU-1:0]       cpu_irq,
    input logic                  msi_irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (msi_cause == '0 && cpu_irq == '0 && !msi_irq));

    // R2 and R5: a ring targeting CPU 0 always lands, even against a clear
    cpu0_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_we && !ring_data[5] && ring_data[8]) |=> cpu_cause[0][$past(ring_data[4:0])]);

    // R3
    msi_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_we && ring_data[5]) |=> msi_cause[$past(ring_data[4:0])]);

    // R3
    msi_cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_we && ring_data[5] && !wr_en) |=> $stable(cpu_cause));

    // R4
    msi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2 && !ring_we) |=> msi_cause == ($past(msi_cause) & $past(wr_data)));

    // R6
    msi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_cause == '0) |-> !msi_irq);

    // R6
    cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cause == '0) |-> cpu_irq == '0);
endmodule

bind ipi_doorbell ipi_doorbell_chk #(.NCPU(NCPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ring_we  (ring_we),
    .ring_data(ring_data),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cpu_cause(cpu_cause),
    .msi_cause(msi_cause),
    .cpu_irq  (cpu_irq),
    .msi_irq  (msi_irq)
);

// File: tb/ipi_doorbell_bench.sv
module ipi_doorbell_bench;
    localparam int NCPU = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ring_we = 1'b0;
    logic [31:0] ring_data = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [1:0]  wr_cpu = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [1:0]  rd_cpu = '0;
    logic [31:0] rd_data;
    logic [NCPU-1:0] cpu_irq;
    logic        msi_irq;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    ipi_doorbell #(.NCPU(NCPU)) u_ipi_doorbell (
        .clk(clk), .rst_n(rst_n), .ring_we(ring_we), .ring_data(ring_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_cpu(wr_cpu), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_cpu(rd_cpu), .rd_data(rd_data),
        .cpu_irq(cpu_irq), .msi_irq(msi_irq)
    );

    // monitor: pops expectations and compares them against the outputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rd_data;
                    1:       act = {28'b0, cpu_irq};
                    default: act = {31'b0, msi_irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle_inputs();
        ring_we = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic do_ring(input logic [31:0] d);
        @(negedge clk);
        ring_we = 1'b1; ring_data = d; wr_en = 1'b0;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_write(input logic [1:0] s, input logic [1:0] c, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_cpu = c; wr_data = d; ring_we = 1'b0;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_both(input logic [31:0] rd, input logic [1:0] s,
                           input logic [1:0] c, input logic [31:0] d);
        @(negedge clk);
        ring_we = 1'b1; ring_data = rd;
        wr_en = 1'b1; wr_sel = s; wr_cpu = c; wr_data = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic push_check(input int k, input logic [31:0] e, input string tag);
        sb_q.push_back('{kind: k, exp: e, tag: tag});
        @(posedge clk);
        #2;
    endtask

    task automatic exp_rd(input logic [1:0] s, input logic [1:0] c,
                          input logic [31:0] e, input string tag);
        @(negedge clk);
        idle_inputs();
        rd_sel = s; rd_cpu = c;
        push_check(0, e, tag);
    endtask

    task automatic exp_cpu_irq(input logic [3:0] e, input string tag);
        @(negedge clk);
        push_check(1, {28'b0, e}, tag);
    endtask

    task automatic exp_msi_irq(input logic e, input string tag);
        @(negedge clk);
        push_check(2, {31'b0, e}, tag);
    endtask

    bit done = 1'b0;

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < NCPU; c++) exp_rd(2'd0, 2'(c), 32'h0, "R1 cpu cause");
        exp_rd(2'd1, 2'd0, 32'h0, "R1 cpu mask");
        exp_rd(2'd2, 2'd0, 32'h0, "R1 msi cause");
        exp_rd(2'd3, 2'd0, 32'hFFFF_FFFF, "R1 msi mask");
        exp_cpu_irq(4'h0, "R1 cpu_irq");
        exp_msi_irq(1'b0, "R1 msi_irq");

        // R2 ring doorbell 3 on CPUs 0 and 2
        do_ring(32'h0000_0503);
        exp_rd(2'd0, 2'd0, 32'h0000_0008, "R2 cpu0");
        exp_rd(2'd0, 2'd1, 32'h0, "R2 cpu1 untouched");
        exp_rd(2'd0, 2'd2, 32'h0000_0008, "R2 cpu2");
        exp_rd(2'd0, 2'd3, 32'h0, "R2 cpu3 untouched");
        exp_cpu_irq(4'h0, "R6 masked");

        do_write(2'd1, 2'd0, 32'hFFFF_FFFF);
        exp_cpu_irq(4'h1, "R6 cpu0 unmasked");

        // R3 redirect to message bank, doorbell 7, target bits ignored
        do_ring(32'h0000_0F27);
        exp_rd(2'd2, 2'd0, 32'h0000_0080, "R3 msi cause");
        exp_rd(2'd0, 2'd0, 32'h0000_0008, "R3 cpu0 unchanged");
        exp_rd(2'd0, 2'd1, 32'h0, "R3 cpu1 unchanged");
        exp_msi_irq(1'b1, "R6 msi_irq");

        // R8 bits 7:6 and target bit 13 ignored
        do_ring(32'h0000_22C4);
        exp_rd(2'd0, 2'd1, 32'h0000_0010, "R8 cpu1 doorbell 4");
        exp_rd(2'd0, 2'd3, 32'h0, "R8 cpu3 untouched");

        // R4 write-zero-to-clear
        do_ring(32'h0000_0109);
        do_write(2'd0, 2'd0, 32'hFFFF_FFF7);
        exp_rd(2'd0, 2'd0, 32'h0000_0200, "R4 cpu0 clear bit 3");
        exp_cpu_irq(4'h1, "R6 cpu0 still pending");

        // R7 mask leaves cause alone
        do_write(2'd1, 2'd0, 32'h0);
        exp_cpu_irq(4'h0, "R7 masked low");
        exp_rd(2'd0, 2'd0, 32'h0000_0200, "R7 cause kept");
        do_write(2'd1, 2'd0, 32'hFFFF_FFFF);
        exp_cpu_irq(4'h1, "R7 unmasked high");

        // R5 ring and clear together
        do_both(32'h0000_0109, 2'd0, 2'd0, 32'h0);
        exp_rd(2'd0, 2'd0, 32'h0000_0200, "R5 cpu0 ring wins");
        do_both(32'h0000_0021, 2'd2, 2'd0, 32'hFFFF_FF7F);
        exp_rd(2'd2, 2'd0, 32'h0000_0002, "R5 msi ring wins");

        // R6 message mask, R7 cause kept
        do_write(2'd3, 2'd0, 32'h0);
        exp_msi_irq(1'b0, "R6 msi masked");
        exp_rd(2'd2, 2'd0, 32'h0000_0002, "R7 msi cause kept");

        // R4 full clear
        do_write(2'd0, 2'd0, 32'h0);
        exp_rd(2'd0, 2'd0, 32'h0, "R4 cpu0 cleared");
        exp_cpu_irq(4'h0, "R6 cpu0 low after clear");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule